// File: doc/BRIEF.md
# Interrupt Moderation Timer

This block delays interrupt delivery until a programmed number of microseconds has gone by. Software programs a threshold and sets the control bits. A counter then advances once per microsecond tick. The tick comes either from an internal prescaler that divides the core clock, or from a pulse on an external tick pin. When the count reaches the threshold, the block sets a sticky status bit and drives a single-cycle moderation event. The interrupt cause logic downstream uses that event.

Software reaches three 32-bit registers through a word-indexed write/read port:

| Index | Register  | Access     |
|-------|-----------|------------|
| 0     | threshold | read/write |
| 1     | live count | read-only |
| 2     | control   | see R11    |

Control register bits:

| Bit | Meaning |
|-----|---------|
| 0   | enable |
| 1   | external tick select |
| 2   | repeat (free-running) |
| 3   | clear (write-only) |
| 4   | threshold-reached status (read-only) |

In one-shot mode the count stops at the threshold. In repeat mode the count restarts from zero after every event. Read data is registered: it shows the addressed register one clock after the address is presented.

Top module: `imod_timer`

## Requirements
- R1: After synchronous reset, the threshold reads `RST_TRSH` (default 300), the count reads 0, the control register reads 0, and `evt_o` is low.
- R2: Registers are selected by word index on `addr_i`: 0 is the threshold, 1 is the live count, 2 is control. Read data appears on `rdata_o` one clock after the index is applied. A threshold write reads back unchanged when it is within range.
- R3: A threshold write above `TRSH_MAX` (default 5,000,000) is stored as `TRSH_MAX`.
- R4: Writes to the count register (index 1) are ignored, and the count keeps its value.
- R5: With enable (bit 0) and external tick select (bit 1) set, each one-cycle pulse on `ext_tick_i` advances the count by exactly one.
- R6: With external tick select at 0, the count advances once every `DIV` clocks. After a control write that enables the block and clears it, the event appears `THR*DIV+1` clocks after that write's clock edge.
- R7: A tick that brings the count up to the threshold sets the status bit (bit 4) and raises `evt_o` for exactly one cycle.
- R8: With repeat (bit 2) at 0, the count holds at the threshold after an event. Further ticks then produce no event until a clear.
- R9: With repeat at 1, the count returns to 0 on each event, and an event is produced every threshold-many ticks.
- R10: While enable is 0, ticks leave the count unchanged and no event is produced.
- R11: Writing control with bit 3 set zeroes the count and the status bit. Bit 3 always reads back as 0. Bits 0 to 2 written in the same write take effect. Bit 4 of a write is ignored.
- R12: The status bit is sticky. It survives the count restarting in repeat mode and survives disabling. Only a clear or a reset removes it.
- R13: If the threshold is lowered to or below the count, the next tick produces an event. In one-shot mode the count then equals the new threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Register write data |
| ext_tick_i | input | 1 | External microsecond tick pulse |
| rdata_o | output | 32 | Registered read data of the addressed register |
| evt_o | output | 1 | One-cycle moderation event |

## Verification
The bench builds the block with `DIV` set to 4, so the internal prescaler path produces an event within thirteen clocks and its exact latency can be counted edge by edge. The threshold width, the maximum of 5,000,000 and the reset value of 300 keep their defaults, so the clamp and the reset value are checked at their real values. Most counting scenarios use the external tick, which fixes the tick count exactly: one-shot hold, repeat rearm, sticky status, disable, clear and a threshold lowered below the count.

// File: rtl/imod_pkg.sv
`timescale 1ns/1ps
package imod_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_THR = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd2;

  localparam int B_EN  = 0;
  localparam int B_EXT = 1;
  localparam int B_REP = 2;
  localparam int B_CLR = 3;
  localparam int B_HIT = 4;

  typedef struct packed {
    logic en;
    logic ext;
    logic rep;
  } ctl_t;
endpackage

// File: rtl/imod_regs.sv
`timescale 1ns/1ps
module imod_regs
  import imod_pkg::*;
#(
  parameter int CNT_W    = 23,
  parameter int TRSH_MAX = 5000000,
  parameter int RST_TRSH = 300
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              hit_i,
  output logic [CNT_W-1:0]  thr_o,
  output ctl_t              ctl_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] MAX_W = DATA_W'(TRSH_MAX);
  localparam logic [DATA_W-1:0] RST_W = DATA_W'(RST_TRSH);
  localparam int PAD = DATA_W - CNT_W;

  logic              thr_wr, ctl_wr;
  logic [DATA_W-1:0] thr_lim;
  logic [DATA_W-1:0] rd_mux;

  assign thr_wr  = wr_en_i && (addr_i == A_THR);
  assign ctl_wr  = wr_en_i && (addr_i == A_CTL);
  assign clr_o   = ctl_wr && wdata_i[B_CLR];
  assign thr_lim = (wdata_i > MAX_W) ? MAX_W : wdata_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      thr_o <= RST_W[CNT_W-1:0];
      ctl_o <= '0;
    end else begin
      if (thr_wr) thr_o <= thr_lim[CNT_W-1:0];
      if (ctl_wr) begin
        ctl_o.en  <= wdata_i[B_EN];
        ctl_o.ext <= wdata_i[B_EXT];
        ctl_o.rep <= wdata_i[B_REP];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_THR: rd_mux = {{PAD{1'b0}}, thr_o};
      A_CNT: rd_mux = {{PAD{1'b0}}, count_i};
      A_CTL: begin
        rd_mux[B_EN]  = ctl_o.en;
        rd_mux[B_EXT] = ctl_o.ext;
        rd_mux[B_REP] = ctl_o.rep;
        rd_mux[B_HIT] = hit_i;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_mux;
  end
endmodule

// File: rtl/imod_tick_gen.sv
`timescale 1ns/1ps
module imod_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic ext_sel_i,
  input  logic clr_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  logic int_tick;

  generate
    if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || ext_sel_i || clr_i) pre_q <= '0;
        else if (pre_q == LAST)                   pre_q <= '0;
        else                                      pre_q <= pre_q + 1'b1;
      end
      assign int_tick = (pre_q == LAST);
    end else begin : g_nodiv
      assign int_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_o <= 1'b0;
    else       tick_o <= en_i && !clr_i && (ext_sel_i ? ext_tick_i : int_tick);
  end
endmodule

// File: rtl/imod_counter.sv
`timescale 1ns/1ps
module imod_counter #(
  parameter int CNT_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             rep_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o,
  output logic             evt_o
);
  logic [CNT_W:0] nxt;
  logic           adv, reach;

  assign nxt   = {1'b0, count_o} + 1'b1;
  assign adv   = en_i && tick_i && !(hit_o && !rep_i);
  assign reach = (nxt >= {1'b0, thr_i});

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_o <= '0;
      hit_o   <= 1'b0;
      evt_o   <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (clr_i) begin
        count_o <= '0;
        hit_o   <= 1'b0;
      end else if (adv) begin
        if (reach) begin
          hit_o   <= 1'b1;
          evt_o   <= 1'b1;
          count_o <= rep_i ? '0 : thr_i;
        end else begin
          count_o <= nxt[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/imod_timer.sv
`timescale 1ns/1ps
module imod_timer
  import imod_pkg::*;
#(
  parameter int DIV      = 100,
  parameter int CNT_W    = 23,
  parameter int TRSH_MAX = 5000000,
  parameter int RST_TRSH = 300
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              ext_tick_i,
  output logic [31:0]       rdata_o,
  output logic              evt_o
);
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] count;
  ctl_t             ctl;
  logic             clr_pulse;
  logic             hit;
  logic             tick;

  imod_regs #(.CNT_W(CNT_W), .TRSH_MAX(TRSH_MAX), .RST_TRSH(RST_TRSH)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .count_i (count),
    .hit_i   (hit),
    .thr_o   (thr),
    .ctl_o   (ctl),
    .clr_o   (clr_pulse),
    .rdata_o (rdata_o)
  );

  imod_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (ctl.en),
    .ext_sel_i  (ctl.ext),
    .clr_i      (clr_pulse),
    .ext_tick_i (ext_tick_i),
    .tick_o     (tick)
  );

  imod_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (ctl.en),
    .rep_i   (ctl.rep),
    .clr_i   (clr_pulse),
    .tick_i  (tick),
    .thr_i   (thr),
    .count_o (count),
    .hit_o   (hit),
    .evt_o   (evt_o)
  );
endmodule

// File: rtl/imod_timer_chk.sv
`timescale 1ns/1ps
module imod_timer_chk #(
  parameter int CNT_W    = 23,
  parameter int TRSH_MAX = 5000000
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] thr,
  input logic             hit,
  input logic             evt
);
  p_thr_clamp_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    32'(thr) <= 32'(TRSH_MAX));

  p_evt_sets_hit_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    evt |-> hit);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en && !clr) |=> $stable(count));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !en |=> !evt);

  p_clear_zero_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    clr |=> (count == '0 && !hit && !evt));

  p_sticky_hit_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit && !clr) |=> hit);
endmodule

bind imod_timer imod_timer_chk #(.CNT_W(CNT_W), .TRSH_MAX(TRSH_MAX)) u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .en    (ctl.en),
  .clr   (clr_pulse),
  .count (count),
  .thr   (thr),
  .hit   (hit),
  .evt   (evt_o)
);

// File: tb/imod_timer_tb.sv
`timescale 1ns/1ps
module imod_timer_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic        ext_tick = 1'b0;
  logic [31:0] rdata;
  logic        evt;

  int n_chk = 0;
  int n_bad = 0;
  int evt_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  imod_timer #(.DIV(DIV)) u_dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .ext_tick_i (ext_tick),
    .rdata_o    (rdata),
    .evt_o      (evt)
  );

  always @(negedge clk) if (!rst && evt) evt_seen++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 evt after reset", {31'b0, evt}, 32'd0);
    rd(2'd0, d); check("R1 threshold reset", d, 32'd300);
    rd(2'd1, d); check("R1 count reset", d, 32'd0);
    rd(2'd2, d); check("R1 control reset", d, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'd17);         rd(2'd0, d); check("R2 threshold readback", d, 32'd17);
    wr(2'd0, 32'hFFFF_FFFF);  rd(2'd0, d); check("R3 clamp all-ones", d, 32'd5000000);
    wr(2'd0, 32'd5000001);    rd(2'd0, d); check("R3 clamp max+1", d, 32'd5000000);
    wr(2'd0, 32'd5000000);    rd(2'd0, d); check("R3 max kept", d, 32'd5000000);
    wr(2'd1, 32'h55);         rd(2'd1, d); check("R4 count write ignored", d, 32'd0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    int e0;
    wr(2'd0, 32'd3);
    wr(2'd2, 32'h0B);
    e0 = evt_seen;
    pulse(1); rd(2'd1, d); check("R5 one ext tick", d, 32'd1);
    pulse(1); rd(2'd1, d); check("R5 two ext ticks", d, 32'd2);
    check("R7 no event below threshold", 32'(evt_seen - e0), 32'd0);
    pulse(1);
    check("R7 single-cycle event at threshold", 32'(evt_seen - e0), 32'd1);
    rd(2'd2, d); check("R7 status bit set", d, 32'h13);
    pulse(2);
    rd(2'd1, d); check("R8 count holds at threshold", d, 32'd3);
    check("R8 no further events", 32'(evt_seen - e0), 32'd1);
  endtask

  task automatic t_repeat;
    logic [31:0] d;
    int e0;
    wr(2'd0, 32'd2);
    wr(2'd2, 32'h0F);
    e0 = evt_seen;
    pulse(5);
    check("R9 two events in five ticks", 32'(evt_seen - e0), 32'd2);
    rd(2'd1, d); check("R9 count rearmed", d, 32'd1);
    rd(2'd2, d); check("R12 status kept across rearm", d, 32'h17);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    int e0;
    wr(2'd2, 32'h06);
    e0 = evt_seen;
    pulse(3);
    rd(2'd1, d); check("R10 count held while disabled", d, 32'd1);
    check("R10 no event while disabled", 32'(evt_seen - e0), 32'd0);
    rd(2'd2, d); check("R12 status kept while disabled", d, 32'h16);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(2'd2, 32'h1B);
    rd(2'd2, d); check("R11 clear bit reads 0, status cleared", d, 32'h03);
    rd(2'd1, d); check("R11 count zeroed", d, 32'd0);
  endtask

  task automatic t_lower;
    logic [31:0] d;
    int e0;
    wr(2'd0, 32'd10);
    wr(2'd2, 32'h0B);
    pulse(4);
    rd(2'd1, d); check("R13 count before lowering", d, 32'd4);
    e0 = evt_seen;
    wr(2'd0, 32'd2);
    pulse(1);
    check("R13 event after lowering", 32'(evt_seen - e0), 32'd1);
    rd(2'd1, d); check("R13 count equals new threshold", d, 32'd2);
  endtask

  task automatic t_internal;
    int first = 0;
    wr(2'd0, 32'd3);
    wr(2'd2, 32'h09);
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (evt && first == 0) first = k;
    end
    check("R6 internal prescaler event latency", 32'(first), 32'(3 * DIV + 1));
    wr(2'd2, 32'h08);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_regs;
    t_oneshot;
    t_repeat;
    t_disable;
    t_clear;
    t_lower;
    t_internal;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule